// File: doc/BRIEF.md
# Prescaled Start/Stop Timer Peripheral

This block is a down-counting timer that software drives through four word-wide registers on a simple 32-bit write/read bus. Software first loads a prescale value and an initial count while the timer is idle. It then writes a start command. From that point a prescale counter divides the clock. Each time the prescale counter expires, the main count drops by one.

While the timer runs, the timer register returns the live count, and both configuration registers refuse writes. Software can halt the timer early with a stop command. Otherwise the timer stops by itself when the count reaches zero and leaves the count at zero. The start command only has an effect while the timer is idle, and the stop command only while it runs.

Reads are combinational from the word address. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the run flag is 0, and the prescale and timer registers read 0.
- R2: Word address 0 is the command register: bit 0 = start, bit 1 = stop, and it reads as 0. Word address 1 is status: bit 0 = running, and the upper bits read 0. Word address 2 is the prescale value. Word address 3 is the timer count. While the timer is idle, a write to address 2 or 3 reads back unchanged.
- R3: A command write with bit 0 set while idle sets the running bit on that same clock edge, and it reloads the prescale counter from the prescale register.
- R4: A start command while running has no effect: the count sequence and the prescale phase continue undisturbed.
- R5: A stop command while running clears the running bit on that edge, and the count then holds its value.
- R6: A stop command while idle has no effect: the running bit stays 0 and the timer register keeps its value.
- R7: With prescale value P, the count drops by exactly one on every (P+1)-th clock edge after the start edge.
- R8: The running bit clears on the same edge that the count reaches zero, and the count then stays at zero. A start with a count of 0 runs for one cycle and then clears.
- R9: Writes to the prescale and timer registers are ignored while the timer runs.
- R10: While the timer runs, reading the timer register returns the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe, sampled at the rising edge |
| busAddr | input | 2 | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |

## Verification
A wrong prescale phase appears at the timer register as a count that drops one cycle early or late. The bench reads the count on every cycle around each expected tick, so such an error is visible within P+1 cycles. A wrong run flag appears in the status word at the next cycle after the command edge. It also appears as a count that keeps moving after a stop, or that freezes or wraps instead of holding zero at expiry. A configuration write that leaks through while the timer runs appears at once as a count that departs from the computed schedule, or as a prescale readback that differs after the run ends.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CMD    = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_PRE    = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT  = 2'd3;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_STOP_BIT  = 1;

  typedef struct packed {
    logic loadPre;
    logic loadCount;
    logic start;
    logic stop;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  cmdStart,
  input  logic                  cmdStop,
  input  logic                  expire,
  output logic                  running,
  output tmrStrobe_t            stb
);
  logic cmdWrite;

  always_comb begin
    cmdWrite      = busWe && (busAddr == ADDR_CMD);
    stb.start     = cmdWrite && cmdStart && !running;
    stb.stop      = cmdWrite && cmdStop && running;
    stb.loadPre   = busWe && (busAddr == ADDR_PRE) && !running;
    stb.loadCount = busWe && (busAddr == ADDR_COUNT) && !running;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  running <= 1'b0;
    else if (stb.start)         running <= 1'b1;
    else if (stb.stop || expire) running <= 1'b0;
  end

  // R3: an accepted start leaves the timer running
  a_r3_start_sets: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> running);
  // R6: only a start can raise the run flag
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !stb.start) |=> !running);
  // R5: an accepted stop drops the run flag
  a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.stop |=> !running);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             running,
  input  tmrStrobe_t       stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] preVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] preCnt;
  logic             tick;

  always_comb begin
    tick   = running && (preCnt == '0) && (cntVal != '0);
    expire = running && ((cntVal == '0) || (tick && cntVal == ONE));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preVal <= '0;
      preCnt <= '0;
      cntVal <= '0;
    end else begin
      if (stb.loadPre) preVal <= wrData;
      if (stb.start)        preCnt <= preVal;
      else if (running)     preCnt <= (preCnt == '0) ? preVal : preCnt - ONE;
      if (stb.loadCount)    cntVal <= wrData;
      else if (tick)        cntVal <= cntVal - ONE;
    end
  end

  // R9: prescale value frozen during a run
  a_r9_pre_locked: assert property (@(posedge clk) disable iff (!rstN)
    running |=> $stable(preVal));
  // R7: each tick removes exactly one from the count
  a_r7_dec_one: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (cntVal == $past(cntVal) - ONE));
  // R8: count never wraps below zero
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (running && cntVal == '0) |=> (cntVal == '0));
  // R9: without a tick a running count does not move
  a_r9_count_locked: assert property (@(posedge clk) disable iff (!rstN)
    (running && !tick) |=> $stable(cntVal));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);
  localparam int DATA_W = 32;

  logic              running;
  logic              expire;
  tmrStrobe_t        stb;
  logic [DATA_W-1:0] preVal;
  logic [DATA_W-1:0] cntVal;

  tmr_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .cmdStart (busWdata[CMD_START_BIT]),
    .cmdStop  (busWdata[CMD_STOP_BIT]),
    .expire   (expire),
    .running  (running),
    .stb      (stb)
  );

  tmr_datapath #(.CNT_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .running (running),
    .stb     (stb),
    .wrData  (busWdata),
    .preVal  (preVal),
    .cntVal  (cntVal),
    .expire  (expire)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CMD:    busRdata = '0;
      ADDR_STATUS: busRdata = {{(DATA_W-1){1'b0}}, running};
      ADDR_PRE:    busRdata = preVal;
      default:     busRdata = cntVal;
    endcase
  end

  // R2: status upper bits are always zero
  a_r2_status_low: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_STATUS) |-> (busRdata[DATA_W-1:1] == '0));
endmodule

// File: tb/prescaled_timer_tb_top.sv
module prescaled_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prescaled_timer dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    busAddr = a;
    #0.5;
    v = busRdata;
  endtask

  // returns at the negedge right after the edge that applied the write
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(2'd1, v); check("R1 status", v, 0);
    rd(2'd2, v); check("R1 prescale", v, 0);
    rd(2'd3, v); check("R1 count", v, 0);
    rd(2'd0, v); check("R2 cmd reads 0", v, 0);
  endtask

  task automatic testIdleWrites();
    logic [31:0] v;
    wr(2'd2, 32'hDEAD_BEEF);
    wr(2'd3, 32'h1234_5678);
    rd(2'd2, v); check("R2 prescale rb", v, 32'hDEAD_BEEF);
    rd(2'd3, v); check("R2 count rb", v, 32'h1234_5678);
  endtask

  task automatic testTickSchedule();
    logic [31:0] v;
    wr(2'd2, 3); wr(2'd3, 5);
    wr(2'd0, 32'h1);                 // m = 0
    rd(2'd1, v); check("R3 running", v, 1);
    for (int m = 1; m <= 22; m++) begin
      @(negedge clk);
      rd(2'd3, v);
      check("R7 R10 live count", v, (m >= 20) ? 0 : 5 - m / 4);
      rd(2'd1, v);
      check("R8 run flag", v, (m >= 20) ? 0 : 1);
    end
  endtask

  task automatic testStop();
    logic [31:0] v;
    wr(2'd2, 0); wr(2'd3, 100);
    wr(2'd0, 32'h1);                 // m = 0
    cyc(10);                         // m = 10
    rd(2'd3, v); check("R10 count m10", v, 90);
    wr(2'd0, 32'h2);                 // stop at edge m = 12
    rd(2'd1, v); check("R5 stopped", v, 0);
    rd(2'd3, v); check("R5 count at stop", v, 88);
    cyc(5);
    rd(2'd3, v); check("R5 count holds", v, 88);
  endtask

  task automatic testStopIdle();
    logic [31:0] v;
    wr(2'd3, 7);
    wr(2'd0, 32'h2);
    rd(2'd1, v); check("R6 still idle", v, 0);
    cyc(3);
    rd(2'd3, v); check("R6 count kept", v, 7);
  endtask

  task automatic testRestartIgnored();
    logic [31:0] v;
    wr(2'd2, 1); wr(2'd3, 10);
    wr(2'd0, 32'h1);                 // m = 0
    cyc(3);
    rd(2'd3, v); check("R7 m3", v, 9);
    wr(2'd0, 32'h1);                 // second start at edge m = 5
    rd(2'd3, v); check("R4 m5", v, 8);
    cyc(1);
    rd(2'd3, v); check("R4 m6 phase kept", v, 7);
    cyc(14);                         // m = 20
    rd(2'd3, v); check("R8 end count", v, 0);
    rd(2'd1, v); check("R8 end flag", v, 0);
  endtask

  task automatic testLocked();
    logic [31:0] v;
    wr(2'd2, 0); wr(2'd3, 50);
    wr(2'd0, 32'h1);                 // m = 0
    wr(2'd2, 9);                     // m = 2
    wr(2'd3, 1000);                  // m = 4
    rd(2'd3, v); check("R9 count write ignored", v, 46);
    wr(2'd0, 32'h2);                 // stop at m = 6
    rd(2'd2, v); check("R9 prescale write ignored", v, 0);
    rd(2'd3, v); check("R9 count after stop", v, 44);
  endtask

  task automatic testZeroStart();
    logic [31:0] v;
    wr(2'd3, 0);
    wr(2'd0, 32'h1);
    rd(2'd1, v); check("R8 zero start runs", v, 1);
    cyc(1);
    rd(2'd1, v); check("R8 zero start ends", v, 0);
    rd(2'd3, v); check("R8 zero count holds", v, 0);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    testReset();
    testIdleWrites();
    testTickSchedule();
    testStop();
    testStopIdle();
    testRestartIgnored();
    testLocked();
    testZeroStart();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule